// File: doc/BRIEF.md
# Two-Tone DAC Formatter with Settling Trigger

This block sits between a digital source that produces two signed tones and an external converter loopback. Each clock it adds the two tone samples into a sum one bit wider than either tone. It then recodes that sum from two's complement to offset binary, because the converter expects unsigned codes. The result is registered, so the word that leaves the block comes straight from a flop and the clock-to-output path stays short.

Beside the data path, a gated counter produces a one-cycle trigger pulse that repeats at a fixed period of enabled clocks. Reset clears the counter, so the first pulse, and therefore its falling edge, cannot come before a full period of enabled clocks after reset. That interval gives the analog chain time to settle before a capture instrument arms on the edge. The reset input is asynchronous and active low. Its release is synchronised inside the block, so internal state leaves reset on the second rising clock edge after the input goes high.

Top module: `tone_dac_trigger`

## Requirements
- R1: The two 13-bit signed tone inputs are added into a 14-bit signed sum. No pair of input values can overflow it: +4095 + +4095 and -4096 + -4096 are both represented exactly.
- R2: The DAC word is the 14-bit sum plus 8192, taken modulo 16384. In other words, the most significant bit is inverted: a sum of -8192 gives code 0, a sum of 0 gives 8192, and a sum of +8190 gives 16382.
- R3: The DAC word is registered. It shows the code for the tones present at a rising edge from that edge on, and it updates whether or not the enable is high.
- R4: While the reset input is low, the DAC word is 8192 (midscale) and the trigger output is 0, without waiting for a clock edge. Internal state leaves reset on the second rising edge after the reset input goes high.
- R5: After reset, the trigger output goes high just after the 4095th rising edge at which the enable is sampled high. It then goes high again after every further 4095 enabled edges.
- R6: The trigger pulse is high for exactly one clock cycle.
- R7: At an edge where the enable is sampled low, the counter holds its value and the trigger output is 0. Counting resumes from the held value when the enable returns.
- R8: If the enable drops just as the count reaches its terminal value, the pulse is deferred. It appears after the first enabled edge once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Counter enable |
| tone_a | input | 13 | First signed tone sample |
| tone_b | input | 13 | Second signed tone sample |
| dac_word | output | 14 | Registered offset-binary DAC code |
| count_hit | output | 1 | One-cycle trigger pulse |

## Verification
The assertions assume that the tone inputs and the enable are stable around each rising edge. They also assume that the reset input changes only while the design is idle or at a point the checker can discount, since the properties are disabled while the synchronised reset is low. The bench changes every input on the falling clock edge and samples outputs on the falling edge, so each input is settled half a period before the edge that uses it. The tone vectors cover both extremes of the sum, zero, and mixed signs. The enable is toggled at an arbitrary count and again exactly at the terminal count.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int TONE_W_DEF = 13;
  localparam int PERIOD_DEF = 4095;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/tdt_rst_sync.sv
module tdt_rst_sync #(
  parameter int STAGES = tdt_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tdt_tone_sum.sv
module tdt_tone_sum #(
  parameter int TONE_W = tdt_pkg::TONE_W_DEF,
  localparam int SUM_W = TONE_W + 1
) (
  input  logic signed [TONE_W-1:0] tone_a,
  input  logic signed [TONE_W-1:0] tone_b,
  output logic signed [SUM_W-1:0]  sum
);
  logic signed [SUM_W-1:0] ext_a, ext_b;

  always_comb begin
    ext_a = {tone_a[TONE_W-1], tone_a};
    ext_b = {tone_b[TONE_W-1], tone_b};
    sum   = ext_a + ext_b;
  end
endmodule

// File: rtl/tdt_offset_reg.sv
module tdt_offset_reg #(
  parameter int W = tdt_pkg::TONE_W_DEF + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] sum,
  output logic        [W-1:0] code
);
  localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_d;

  always_comb begin
    code_d = {~sum[W-1], sum[W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= MIDSCALE;
    else        code <= code_d;
  end
endmodule

// File: rtl/tdt_settle_counter.sv
module tdt_settle_counter #(
  parameter int PERIOD = tdt_pkg::PERIOD_DEF,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             hit_d;
  logic             at_last;

  always_comb begin
    at_last = (cnt == LAST);
    cnt_d   = cnt;
    hit_d   = 1'b0;
    if (en) begin
      hit_d = at_last;
      cnt_d = at_last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      cnt <= cnt_d;
      hit <= hit_d;
    end
  end
endmodule

// File: rtl/tone_dac_trigger.sv
module tone_dac_trigger #(
  parameter int TONE_W = tdt_pkg::TONE_W_DEF,
  parameter int PERIOD = tdt_pkg::PERIOD_DEF,
  localparam int SUM_W = TONE_W + 1,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic signed [TONE_W-1:0] tone_a,
  input  logic signed [TONE_W-1:0] tone_b,
  output logic        [SUM_W-1:0]  dac_word,
  output logic                     count_hit
);
  logic                    rst_n_s;
  logic signed [SUM_W-1:0] tone_sum;
  logic [CNT_W-1:0]        settle_cnt;

  tdt_rst_sync #(.STAGES(tdt_pkg::SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  tdt_tone_sum #(.TONE_W(TONE_W)) u_sum (
    .tone_a(tone_a), .tone_b(tone_b), .sum(tone_sum)
  );

  tdt_offset_reg #(.W(SUM_W)) u_fmt (
    .clk(clk), .rst_n(rst_n_s), .sum(tone_sum), .code(dac_word)
  );

  tdt_settle_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .en(clk_en), .cnt(settle_cnt), .hit(count_hit)
  );
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int TONE_W = tdt_pkg::TONE_W_DEF,
  parameter int PERIOD = tdt_pkg::PERIOD_DEF,
  localparam int SUM_W = TONE_W + 1,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input logic                     clk,
  input logic                     rst_n_s,
  input logic                     clk_en,
  input logic signed [TONE_W-1:0] tone_a,
  input logic signed [TONE_W-1:0] tone_b,
  input logic        [SUM_W-1:0]  dac_word,
  input logic                     count_hit,
  input logic        [CNT_W-1:0]  settle_cnt
);
  localparam int OFFSET = 1 << (SUM_W - 1);

  // R2
  offset_code_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> dac_word ==
      SUM_W'(int'($past(tone_a)) + int'($past(tone_b)) + OFFSET));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    count_hit |=> !count_hit);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !clk_en |=> ($stable(settle_cnt) && !count_hit));

  // R5
  pulse_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(count_hit) |-> ($past(settle_cnt) == CNT_W'(PERIOD - 1)) && settle_cnt == '0);

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    settle_cnt <= CNT_W'(PERIOD - 1));
endmodule

bind tone_dac_trigger tdt_checker #(.TONE_W(TONE_W), .PERIOD(PERIOD)) chk (
  .clk(clk), .rst_n_s(rst_n_s), .clk_en(clk_en), .tone_a(tone_a),
  .tone_b(tone_b), .dac_word(dac_word), .count_hit(count_hit),
  .settle_cnt(settle_cnt)
);

// File: tb/tone_dac_trigger_test.sv
module tone_dac_trigger_test;
  localparam int PER = 4095;

  logic clk = 1'b0;
  logic rst_n, clk_en;
  logic signed [12:0] tone_a, tone_b;
  logic [13:0] dac_word;
  logic count_hit;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tone_dac_trigger uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tone_a(tone_a),
    .tone_b(tone_b), .dac_word(dac_word), .count_hit(count_hit)
  );

  always #4 clk = ~clk;

  localparam int NV = 9;
  localparam int VA [NV] = '{0, 4095, -4096, 4095, 1, -1, 100, -4096, 2047};
  localparam int VB [NV] = '{0, 4095, -4096, -4096, 0, 0, -300, 4095, 2048};
  localparam int VE [NV] = '{8192, 16382, 0, 8191, 8193, 8191, 7992, 8191, 12287};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clk_en = 1'b0;
    #1;
    // R4: asynchronous clear
    check("R4 dac midscale", dac_word, 8192);
    check("R4 trigger low", count_hit, 0);
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int first, highs, k2;
    rst_n = 1'b0; clk_en = 1'b0; tone_a = '0; tone_b = '0;
    step(2);
    rst_n = 1'b1;
    step(3);
    check("R4 reset dac", dac_word, 8192);
    check("R4 reset trigger", count_hit, 0);

    // R1 R2 R3: vector table
    for (int i = 0; i < NV; i++) begin
      tone_a = 13'(VA[i]);
      tone_b = 13'(VB[i]);
      clk_en = i[0];
      step(1);
      check("R1 R2 R3 code", dac_word, VE[i]);
    end

    // R5 R6: first and second pulse
    do_reset();
    clk_en = 1'b1;
    first = -1; highs = 0; k2 = -1;
    for (int k = 1; k <= 2 * PER + 1; k++) begin
      step(1);
      if (count_hit) begin
        if (first < 0) first = k;
        else if (k2 < 0) k2 = k;
        highs++;
      end
    end
    check("R5 first pulse edge", first, PER);
    check("R5 second pulse edge", k2, 2 * PER);
    check("R6 pulse width total", highs, 2);

    // R4: reset mid-run with nonzero tones
    tone_a = 13'sd1000; tone_b = 13'sd500;
    step(1);
    check("R3 running code", dac_word, 9692);
    do_reset();

    // R7: enable gap
    clk_en = 1'b1;
    step(100);
    clk_en = 1'b0;
    highs = 0;
    for (int k = 0; k < 50; k++) begin
      step(1);
      if (count_hit) highs++;
    end
    check("R7 no pulse while idle", highs, 0);
    clk_en = 1'b1;
    first = -1;
    for (int k = 1; k <= PER; k++) begin
      step(1);
      if (count_hit && first < 0) first = k;
    end
    check("R7 resumes from held count", first, PER - 100);

    // R8: enable drops at terminal count
    do_reset();
    clk_en = 1'b1;
    step(PER - 1);
    check("R8 not yet", count_hit, 0);
    clk_en = 1'b0;
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (count_hit) highs++;
    end
    check("R8 deferred while idle", highs, 0);
    clk_en = 1'b1;
    step(1);
    check("R8 pulse on return", count_hit, 1);
    step(1);
    check("R6 pulse ends", count_hit, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule